// File: doc/BRIEF.md
# Same-Line Ordered Miss Holding Buffer

This block parks cache requests that cannot finish in a single pass through the cache pipeline: true misses, misses that found no way to allocate, accesses that hit a tag ECC error, atomics and partial stores that need a second pass, and requests that hit a line which is still owned by an earlier miss or by a pending write-back. Each insert carries a line address, a request tag and a flag that says whether the line must be read from memory. Held requests that target the same line are linked into a chain in arrival order, and only the oldest one in the chain can talk to memory or be replayed. Requests for different lines are unrelated and can complete in any order. Slots are taken from a pool of free entries.

A chain head that needs data raises one memory read, which carries the line address and the entry index. When the memory side reports the critical data for that index, the head becomes eligible for replay. A replay grant hands the tag back to the cache pipeline and frees the slot in the same cycle. The next entry in the chain then becomes the head. Because its line is now resident, it is granted directly, with no second memory read. A full flag tells the producer that no free slot remains.

Top module: `linked_miss_buf`

## Requirements
- R1: `full` is high exactly when all DEPTH entries are occupied, and an insert presented while `full` is high is dropped and never produces a read or a grant.
- R2: An insert whose line matches no held entry and whose `ins_need_rd` is 1 raises `mem_req_valid` for exactly one cycle, with its address on `mem_req_addr` and its entry index on `mem_req_id`, in the cycle after the insert edge.
- R3: An insert whose line matches a held entry is appended behind it and never raises a memory read, whatever the value of `ins_need_rd`.
- R4: A `fill_valid` pulse whose `fill_id` names an entry with a read outstanding makes that entry eligible for replay in the next cycle.
- R5: A fill that names a free entry, an entry still waiting behind an older one, or an entry whose read has not yet been issued has no effect on any output.
- R6: Entries that share a line address are granted strictly in insertion order.
- R7: When a granted entry has a successor, the successor is granted in a later cycle without any memory read for that line.
- R8: Entries for different lines are independent: a younger line whose data returns first is granted before an older line.
- R9: An insert that matches no held line and has `ins_need_rd` at 0 is granted without a memory read.
- R10: At most one memory read and one replay grant are presented per cycle, and when several entries qualify the one with the lowest index is chosen.
- R11: A new entry takes the lowest free index (entry indices run from 0 to DEPTH-1), and a grant frees its index for an insert in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_addr | input | ADDR_W | Line address of the inserted request |
| ins_tag | input | TAG_W | Request tag returned on replay |
| ins_need_rd | input | 1 | 1 when the line must be fetched from memory |
| fill_valid | input | 1 | Critical data returned from memory |
| fill_id | input | $clog2(DEPTH) | Entry index the returned data belongs to |
| mem_req_valid | output | 1 | Memory read request, one cycle per line |
| mem_req_addr | output | ADDR_W | Line address to read |
| mem_req_id | output | $clog2(DEPTH) | Entry index that owns the read |
| rpl_valid | output | 1 | Replay grant; the entry retires in this cycle |
| rpl_id | output | $clog2(DEPTH) | Index of the granted entry |
| rpl_addr | output | ADDR_W | Line address of the granted entry |
| rpl_tag | output | TAG_W | Tag of the granted entry |
| full | output | 1 | No free entry remains |

## Verification
A broken link or a lost head flag shows at the ports as a chain that stalls forever or as a same-line request granted ahead of an older one, visible on the grant after the first fill of that line. A state entry that wrongly returns to the read phase shows as a second memory read for a line already present, one cycle after the grant of its predecessor. A free pool that leaks or double-allocates shows as `full` rising early or as a grant index that belongs to two tags, which the bench's behavioural model detects on the very next clock.

// File: rtl/lmb_pkg.sv
package lmb_pkg;

    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,   // behind an older entry of the same line
        PH_NEED  = 2'd1,   // head, memory read not yet issued
        PH_SENT  = 2'd2,   // head, memory read outstanding
        PH_READY = 2'd3    // head, line present, may be replayed
    } lmb_phase_e;

endpackage

// File: rtl/lmb_pick.sv
// Lowest-index priority pick over a request vector.
module lmb_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lmb_line_cam.sv
// Finds the chain tail that holds a given line address.
module lmb_line_cam #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 26,
    parameter int IW     = 4
) (
    input  logic [ADDR_W-1:0]             key,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  lines,
    input  logic [DEPTH-1:0]              live,
    output logic                          hit,
    output logic [IW-1:0]                 hit_idx
);

    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = live[g] && (lines[g] == key);
    end

    lmb_pick #(.N(DEPTH), .IW(IW)) u_pick (
        .req   (eq),
        .found (hit),
        .idx   (hit_idx)
    );

endmodule

// File: rtl/linked_miss_buf.sv
module linked_miss_buf
    import lmb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 26,
    parameter int TAG_W  = 8,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic              ins_need_rd,
    input  logic              fill_valid,
    input  logic [IW-1:0]     fill_id,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [IW-1:0]     mem_req_id,
    output logic              rpl_valid,
    output logic [IW-1:0]     rpl_id,
    output logic [ADDR_W-1:0] rpl_addr,
    output logic [TAG_W-1:0]  rpl_tag,
    output logic              full
);

    typedef struct packed {
        logic       [DEPTH-1:0]              vld;
        logic       [DEPTH-1:0]              head;
        logic       [DEPTH-1:0]              tail;
        logic       [DEPTH-1:0]              has_nxt;
        logic       [DEPTH-1:0][IW-1:0]      nxt;
        logic       [DEPTH-1:0][ADDR_W-1:0]  addr;
        logic       [DEPTH-1:0][TAG_W-1:0]   tag;
        lmb_phase_e [DEPTH-1:0]              phase;
    } lmb_state_t;

    lmb_state_t st_q, st_d;

    // Per-entry request vectors
    logic [DEPTH-1:0] free_vec;
    logic [DEPTH-1:0] need_vec;
    logic [DEPTH-1:0] ready_vec;
    logic [DEPTH-1:0] retire_mask;
    logic [DEPTH-1:0] tail_live;

    for (genvar g = 0; g < DEPTH; g++) begin : g_vec
        assign free_vec[g]  = ~st_q.vld[g];
        assign need_vec[g]  = st_q.vld[g] && (st_q.phase[g] == PH_NEED);
        assign ready_vec[g] = st_q.vld[g] && (st_q.phase[g] == PH_READY);
        assign retire_mask[g] = rpl_valid && (rpl_id == IW'(g));
        assign tail_live[g] = st_q.vld[g] && st_q.tail[g] && !retire_mask[g];
    end

    logic          alloc_found;
    logic [IW-1:0] alloc_idx;
    logic          mem_found;
    logic [IW-1:0] mem_idx;
    logic          rpl_found;
    logic [IW-1:0] rpl_idx;
    logic          tail_hit;
    logic [IW-1:0] tail_idx;

    lmb_pick #(.N(DEPTH), .IW(IW)) u_alloc (
        .req (free_vec), .found (alloc_found), .idx (alloc_idx)
    );

    lmb_pick #(.N(DEPTH), .IW(IW)) u_mem_arb (
        .req (need_vec), .found (mem_found), .idx (mem_idx)
    );

    lmb_pick #(.N(DEPTH), .IW(IW)) u_rpl_arb (
        .req (ready_vec), .found (rpl_found), .idx (rpl_idx)
    );

    lmb_line_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IW(IW)) u_cam (
        .key     (ins_addr),
        .lines   (st_q.addr),
        .live    (tail_live),
        .hit     (tail_hit),
        .hit_idx (tail_idx)
    );

    // Outputs straight from registered state
    assign full          = ~alloc_found;
    assign mem_req_valid = mem_found;
    assign mem_req_id    = mem_idx;
    assign mem_req_addr  = st_q.addr[mem_idx];
    assign rpl_valid     = rpl_found;
    assign rpl_id        = rpl_idx;
    assign rpl_addr      = st_q.addr[rpl_idx];
    assign rpl_tag       = st_q.tag[rpl_idx];

    logic ins_take;
    assign ins_take = ins_valid && alloc_found;

    always_comb begin
        st_d = st_q;

        // Retire the granted head and promote its successor
        if (rpl_found) begin
            st_d.vld[rpl_idx]     = 1'b0;
            st_d.head[rpl_idx]    = 1'b0;
            st_d.tail[rpl_idx]    = 1'b0;
            st_d.has_nxt[rpl_idx] = 1'b0;
            if (st_q.has_nxt[rpl_idx]) begin
                st_d.head[st_q.nxt[rpl_idx]]  = 1'b1;
                st_d.phase[st_q.nxt[rpl_idx]] = PH_READY;
            end
        end

        // Issue one memory read
        if (mem_found) begin
            st_d.phase[mem_idx] = PH_SENT;
        end

        // Critical data return
        if (fill_valid && st_q.vld[fill_id] && (st_q.phase[fill_id] == PH_SENT)) begin
            st_d.phase[fill_id] = PH_READY;
        end

        // Insert into the lowest free slot
        if (ins_take) begin
            st_d.vld[alloc_idx]     = 1'b1;
            st_d.addr[alloc_idx]    = ins_addr;
            st_d.tag[alloc_idx]     = ins_tag;
            st_d.tail[alloc_idx]    = 1'b1;
            st_d.has_nxt[alloc_idx] = 1'b0;
            st_d.nxt[alloc_idx]     = '0;
            if (tail_hit) begin
                st_d.tail[tail_idx]    = 1'b0;
                st_d.has_nxt[tail_idx] = 1'b1;
                st_d.nxt[tail_idx]     = alloc_idx;
                st_d.head[alloc_idx]   = 1'b0;
                st_d.phase[alloc_idx]  = PH_WAIT;
            end else begin
                st_d.head[alloc_idx]  = 1'b1;
                st_d.phase[alloc_idx] = ins_need_rd ? PH_NEED : PH_READY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    p_full_all_used_r1: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (&st_q.vld));

    p_no_insert_when_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ins_valid && !rpl_valid)
        |=> ($countones(st_q.vld) == $past($countones(st_q.vld))));

    p_req_from_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (st_q.head[mem_req_id] && st_q.vld[mem_req_id]));

    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !(mem_req_valid && (mem_req_id == $past(mem_req_id))));

    p_fill_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && st_q.vld[fill_id] && (st_q.phase[fill_id] == PH_SENT))
        |=> (st_q.phase[$past(fill_id)] == PH_READY));

    p_grant_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_valid |-> (st_q.head[rpl_id] && st_q.vld[rpl_id]));

    p_successor_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rpl_valid && st_q.has_nxt[rpl_id])
        |=> (st_q.head[$past(st_q.nxt[rpl_id])]
             && (st_q.phase[$past(st_q.nxt[rpl_id])] == PH_READY)));

endmodule

// File: tb/linked_miss_buf_test.sv
module linked_miss_buf_test;

    localparam int DEPTH  = 16;
    localparam int ADDR_W = 26;
    localparam int TAG_W  = 8;
    localparam int IW     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ins_valid = 1'b0;
    logic [ADDR_W-1:0] ins_addr = '0;
    logic [TAG_W-1:0]  ins_tag = '0;
    logic              ins_need_rd = 1'b0;
    logic              fill_valid = 1'b0;
    logic [IW-1:0]     fill_id = '0;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [IW-1:0]     mem_req_id;
    logic              rpl_valid;
    logic [IW-1:0]     rpl_id;
    logic [ADDR_W-1:0] rpl_addr;
    logic [TAG_W-1:0]  rpl_tag;
    logic              full;

    linked_miss_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) uut (
        .clk, .rst_n, .ins_valid, .ins_addr, .ins_tag, .ins_need_rd,
        .fill_valid, .fill_id, .mem_req_valid, .mem_req_addr, .mem_req_id,
        .rpl_valid, .rpl_id, .rpl_addr, .rpl_tag, .full
    );

    always #10 clk = ~clk;   // 50 MHz

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    string cur_req = "R1";

    // Behavioural model: 0 free, 1 waiting, 2 needs read, 3 read sent, 4 ready
    int m_st  [DEPTH];
    int m_addr[DEPTH];
    int m_tag [DEPTH];
    int m_seq [DEPTH];
    int seq_ctr = 0;
    int tag_ctr = 1;

    function automatic int lowest(input int ph);
        for (int i = 0; i < DEPTH; i++) if (m_st[i] == ph) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        int g, m, a, s, best;
        bit chain;
        int old_st[DEPTH];
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_st[i] = 0;
        end else begin
            for (int i = 0; i < DEPTH; i++) old_st[i] = m_st[i];
            g = lowest(4);
            m = lowest(2);
            a = lowest(0);
            if (g >= 0) begin
                m_st[g] = 0;
                s = -1; best = 0;
                for (int i = 0; i < DEPTH; i++)
                    if (i != g && old_st[i] != 0 && m_addr[i] == m_addr[g]
                        && (s < 0 || m_seq[i] < best)) begin
                        s = i; best = m_seq[i];
                    end
                if (s >= 0) m_st[s] = 4;
            end
            if (m >= 0) m_st[m] = 3;
            if (fill_valid && old_st[fill_id] == 3) m_st[fill_id] = 4;
            if (ins_valid && a >= 0) begin
                chain = 1'b0;
                for (int i = 0; i < DEPTH; i++)
                    if (i != g && old_st[i] != 0 && m_addr[i] == int'(ins_addr)) chain = 1'b1;
                m_addr[a] = int'(ins_addr);
                m_tag[a]  = int'(ins_tag);
                m_seq[a]  = seq_ctr++;
                m_st[a]   = chain ? 1 : (ins_need_rd ? 2 : 4);
            end
        end
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog %s: actual hung run, expected completion", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // Compare with the model on every clock, away from the edge
    always @(negedge clk) begin
        int m, g;
        if (rst_n) begin
            m = lowest(2);
            g = lowest(4);
            chk(full == (lowest(0) < 0), "full", int'(full), int'(lowest(0) < 0));
            chk(mem_req_valid == (m >= 0), "mem_req_valid", int'(mem_req_valid), int'(m >= 0));
            if (m >= 0 && mem_req_valid) begin
                chk(int'(mem_req_id) == m, "mem_req_id", int'(mem_req_id), m);
                chk(int'(mem_req_addr) == m_addr[m], "mem_req_addr", int'(mem_req_addr), m_addr[m]);
            end
            chk(rpl_valid == (g >= 0), "rpl_valid", int'(rpl_valid), int'(g >= 0));
            if (g >= 0 && rpl_valid) begin
                chk(int'(rpl_id) == g, "rpl_id", int'(rpl_id), g);
                chk(int'(rpl_tag) == m_tag[g], "rpl_tag", int'(rpl_tag), m_tag[g]);
                chk(int'(rpl_addr) == m_addr[g], "rpl_addr", int'(rpl_addr), m_addr[g]);
            end
        end
    end

    task automatic step(input bit iv, input int addr, input bit need,
                        input bit fv, input int fid);
        @(negedge clk);
        ins_valid   = iv;
        ins_addr    = ADDR_W'(addr);
        ins_need_rd = need;
        ins_tag     = TAG_W'(tag_ctr);
        if (iv) tag_ctr++;
        fill_valid  = fv;
        fill_id     = IW'(fid);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R1): nothing held, nothing requested
        chk(!full && !mem_req_valid && !rpl_valid, "reset outputs",
            int'({full, mem_req_valid, rpl_valid}), 0);

        cur_req = "R2";  step(1, 'h10, 1, 0, 0); idle(2);        // id0 reads line 10
        cur_req = "R3";  step(1, 'h10, 1, 0, 0); idle(2);        // id1 chained, no read
        cur_req = "R5";  step(0, 0, 0, 1, 1); idle(1);           // fill of waiting entry
                         step(0, 0, 0, 1, 7); idle(1);           // fill of free entry
        cur_req = "R4";  step(0, 0, 0, 1, 0);
        cur_req = "R7";  idle(4);                                // id0 then id1, no read
        cur_req = "R8";  step(1, 'h20, 1, 0, 0); step(1, 'h30, 1, 0, 0); idle(2);
                         step(0, 0, 0, 1, 1); idle(2);           // younger line first
                         step(0, 0, 0, 1, 0); idle(2);
        cur_req = "R9";  step(1, 'h50, 0, 0, 0); idle(2);
        cur_req = "R10"; step(1, 'h61, 1, 0, 0); step(1, 'h62, 1, 0, 0);
                         step(1, 'h63, 1, 0, 0); idle(3);
                         step(0, 0, 0, 1, 2); step(0, 0, 0, 1, 1);
                         step(0, 0, 0, 1, 0); idle(4);
        cur_req = "R1";  for (int i = 0; i < DEPTH + 3; i++) step(1, 'h40, 1, 0, 0);
                         idle(2);
        chk(full == 1'b1, "full after filling all entries", int'(full), 1);
        cur_req = "R6";  step(0, 0, 0, 1, 0); idle(DEPTH + 3);   // drain in order
        cur_req = "R11"; step(1, 'h70, 0, 0, 0); step(1, 'h71, 0, 0, 0); idle(3);

        cur_req = "R6";
        for (int c = 0; c < 4000; c++) begin
            bit iv, nd, fv;
            int ad, fi;
            iv = ($urandom % 2) == 0;
            nd = ($urandom % 4) != 0;
            ad = 'h100 + ($urandom % 5);
            fv = ($urandom % 2) == 0;
            fi = $urandom % DEPTH;
            step(iv, ad, nd, fv, fi);
        end
        idle(5);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule